// File: doc/BRIEF.md
# Free-Running Cycle Counter with Deadline Interrupt

This block gives one processor core a cycle counter that starts at zero after reset and advances by one on every clock, together with a single deadline register. Software reads the counter through a read-only output and programs a deadline through a write-only 32-bit port. When the low 32 bits of the counter reach the deadline, the block latches a pending flag. That flag drives the interrupt output for as long as interrupts are enabled.

The counter width is a parameter and may be 32 or 64 bits. The deadline is always 32 bits wide and is compared only against the low word of the counter. A deadline that has already been passed therefore stays silent until the low word wraps around to it, which takes 2^32 cycles. Each instance keeps its own count, and nothing aligns the counts of different cores. The pending flag holds until software acknowledges it, and the enable bit only hides or shows the flag on the interrupt output.

Top module: `ivl_timer`

## Requirements
- R1: `count` is an output only, its width is the parameter `CNT_W` (32 or 64), and it reads 0 while reset is held.
- R2: `count` rises by exactly one on every clock edge after reset.
- R3: The deadline is 32 bits, can only be written (`cmp_we`/`cmp_wdata`, effective at the next edge) and cannot be read back. Reset loads it with all ones.
- R4: When the low 32 bits of `count` equal the deadline, the pending flag sets on the following edge. A deadline written as `count+k` (k ≥ 1) at one clock edge therefore raises `irq` after k+1 edges, and not after k.
- R5: `irq` equals pending AND enable. The enable bit is written through `en_we`/`en_wdata` and reset clears it. A match that occurs while interrupts are masked stays pending, hidden, and appears on `irq` as soon as interrupts are enabled.
- R6: A deadline equal to a value the low word has already passed raises no interrupt until the low word wraps around to it.
- R7: Pending holds until a cycle with `ack` high clears it. When a new match and `ack` fall in the same cycle, pending stays set.
- R8: Writing the deadline does not clear a flag that is already pending.
- R9: Reset clears the pending flag and the enable bit, so `irq` is 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we | input | 1 | Deadline write strobe |
| cmp_wdata | input | 32 | Deadline value |
| en_we | input | 1 | Interrupt enable write strobe |
| en_wdata | input | 1 | New interrupt enable value |
| ack | input | 1 | Clears the pending flag |
| count | output | CNT_W | Current counter value |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
Two events can fall in the same cycle: a deadline match and an acknowledge. The bench first makes an earlier match pending. It then programs a deadline ten cycles ahead and raises `ack` in exactly the cycle in which the low counter word equals the deadline. The test passes if `irq` is still high afterwards, because the new match must win over the acknowledge. A lone acknowledge that follows must then drop `irq`. A deadline write made while a flag is pending is judged the same way: `irq` must not fall after that write.

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we,
  input  logic [31:0]      cmp_wdata,
  input  logic             en_we,
  input  logic             en_wdata,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam int CMP_W = 32;

  logic [CNT_W-1:0] cnt_q;
  logic [CMP_W-1:0] cmp_q;
  logic             en_q;
  logic             pend_q;
  logic             hit;

  if (CNT_W != 32 && CNT_W != 64) begin : g_bad_width
    $error("CNT_W must be 32 or 64");
  end

  assign hit = (cnt_q[CMP_W-1:0] == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cmp_we) cmp_q <= cmp_wdata;
      if (en_we)  en_q  <= en_wdata;
      pend_q <= hit | (pend_q & ~ack);
    end
  end

  assign count = cnt_q;
  assign irq   = pend_q & en_q;
endmodule

module ivl_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_we,
  input logic             ack,
  input logic [CNT_W-1:0] count,
  input logic [31:0]      cmp,
  input logic             en,
  input logic             pend,
  input logic             irq
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> count == $past(count) + 1'b1);

  p_match_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count[31:0] == cmp) |=> pend);

  p_mask_hides_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  p_shown_when_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend) |-> irq);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ack && count[31:0] != cmp) |=> !pend);

  p_write_keeps_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cmp_we && !ack) |=> pend);

  p_reset_state_r9: assert property (@(posedge clk)
    $past(!rst_n) |-> (!pend && !en && count == '0 && cmp == '1));
endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .ack(ack), .count(count),
  .cmp(cmp_q), .en(en_q), .pend(pend_q), .irq(irq)
);

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;
  localparam int CNT_W = 64;
  localparam int NV = 5;
  localparam int unsigned OFF[NV] = '{3, 10, 1, 40, 7};
  localparam bit          ENV[NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_we = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic en_we = 1'b0;
  logic en_wdata = 1'b0;
  logic ack = 1'b0;
  logic [CNT_W-1:0] count;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ivl_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .en_we(en_we), .en_wdata(en_wdata), .ack(ack), .count(count), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ack_pulse();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [CNT_W-1:0] c0;
    step(3);
    chk("R1 count in reset", 64'(count), 64'd0);
    chk("R9 irq in reset", 64'(irq), 64'd0);
    rst_n = 1'b1;
    step(1);
    chk("R1 count after first edge", 64'(count), 64'd1);
    c0 = count;
    step(25);
    chk("R2 count step", 64'(count), 64'(c0 + 25));

    en_we = 1'b1; en_wdata = 1'b1; step(1); en_we = 1'b0;
    step(50);
    chk("R3 all-ones deadline quiet", 64'(irq), 64'd0);
    en_we = 1'b1; en_wdata = 1'b0; step(1); en_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cmp_we = 1'b1; cmp_wdata = count[31:0] + OFF[i];
      en_we = 1'b1; en_wdata = ENV[i];
      step(1);
      cmp_we = 1'b0; en_we = 1'b0;
      step(OFF[i] - 1);
      chk("R4 not yet at k edges", 64'(irq), 64'd0);
      step(1);
      chk("R4 fires at k+1 edges / R5 mask", 64'(irq), 64'(ENV[i]));
      if (!ENV[i]) begin
        en_we = 1'b1; en_wdata = 1'b1; step(1); en_we = 1'b0;
        chk("R5 hidden match shown on enable", 64'(irq), 64'd1);
      end
      step(3);
      chk("R7 held without ack", 64'(irq), 64'd1);
      ack_pulse();
      chk("R7 ack clears", 64'(irq), 64'd0);
    end

    cmp_we = 1'b1; cmp_wdata = count[31:0]; step(1); cmp_we = 1'b0;
    step(300);
    chk("R6 passed deadline silent", 64'(irq), 64'd0);

    cmp_we = 1'b1; cmp_wdata = count[31:0] + 2; step(1); cmp_we = 1'b0;
    step(2);
    chk("R4 pending before rewrite", 64'(irq), 64'd1);
    cmp_we = 1'b1; cmp_wdata = count[31:0] + 32'd5000; step(1); cmp_we = 1'b0;
    chk("R8 write keeps pending", 64'(irq), 64'd1);

    cmp_we = 1'b1; cmp_wdata = count[31:0] + 10; step(1); cmp_we = 1'b0;
    step(9);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R7 match beats ack", 64'(irq), 64'd1);
    ack_pulse();
    chk("R7 lone ack clears", 64'(irq), 64'd0);

    cmp_we = 1'b1; cmp_wdata = count[31:0] + 1; step(1); cmp_we = 1'b0;
    step(1);
    chk("R4 pending before reset", 64'(irq), 64'd1);
    rst_n = 1'b0; step(1);
    chk("R9 reset clears irq", 64'(irq), 64'd0);
    chk("R1 reset clears count", 64'(count), 64'd0);
    rst_n = 1'b1; step(1);
    en_we = 1'b1; en_wdata = 1'b1; step(1); en_we = 1'b0;
    chk("R9 pending stays cleared", 64'(irq), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule